// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block drives one asynchronous NAND flash bus access at a time. A host issues a single request: a data transfer, a command byte or an address byte, aimed at one of two chip enables. The block then plays out the pin waveform, with every phase length counted in host clock cycles. Data transfers use the common timing set. Command and address transfers use the attribute timing set, and they hold CLE or ALE high for the whole access.

Each access has up to four phases. A read that directly follows a command or address cycle first waits out a programmable turnaround gap. Setup follows, with chip enable low and the strobe high. The wait phase comes next, with WE or RE low; when enabled, the ready/busy input can stretch it. Hold ends the access, with the strobe high again and chip enable still low. On writes, the data bus drive is turned on a programmable number of cycles into the access.

Software programs the block through a small register write port. Register 0 is the common set and register 1 the attribute set. Register 2 holds the mode bits and register 3 the turnaround delays.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset all chip enables are high, WE and RE are high, CLE, ALE, dq_oe, req_busy and rsp_valid are low. Every field of both timing sets resets to 10, both turnaround delays reset to 15, and the bus is 8 bits wide with bank and wait disabled.
- R2: A timing set word (cfg_sel 0 = common, 1 = attribute) holds setup in bits 7:0, wait in 15:8, hold in 23:16 and drive delay in 31:24. For a data access, chip enable is low for setup+wait+hold cycles. The strobe is low only during the wait cycles, which start setup cycles after chip enable falls.
- R3: req_kind 0 is data, 1 is command and 2 is address; the value 3 acts as data. Command and address requests are always writes, use the attribute set, and hold CLE (command) or ALE (address) high for every cycle in which chip enable is low.
- R4: Only the chip enable selected by req_cs goes low during an access.
- R5: On writes, dq_oe rises drive-delay+1 cycles after setup begins and stays high until the last hold cycle. dq_out carries the request data while dq_oe is high, and RE stays high whenever dq_oe is high.
- R6: On a data read, RE is low during the wait phase and dq_in is sampled in the last wait cycle. The sampled value appears on rsp_rdata, with rsp_valid high for one cycle: the first hold cycle.
- R7: Mode register (cfg_sel 2) bit 2 selects a 16-bit bus. In 8-bit mode the upper byte of dq_out and of rsp_rdata is zero.
- R8: With mode bit 1 (wait enable) set, a low rnb keeps the wait phase going past its programmed length until rnb is sampled high. With the bit clear, rnb has no effect.
- R9: With mode bit 0 (bank enable) clear, requests are ignored: req_busy stays low and no chip enable falls.
- R10: req_busy is high from the cycle after a request is accepted through the last hold cycle. Requests made while req_busy is high are ignored.
- R11: A setup, wait or hold field programmed as 0 behaves as 1.
- R12: A data read that directly follows a command cycle starts its setup after cmd-delay+1 idle cycles. After an address cycle the gap is addr-delay+1 cycles, and after a data access there is no gap. The delays sit in register 3: command delay in bits 3:0, address delay in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 common set, 1 attribute set, 2 mode, 3 delays |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 data, 1 command, 2 address |
| req_write | input | 1 | Data direction, 1 = write |
| req_cs | input | CSW | Target chip enable index |
| req_wdata | input | DW | Write data or command/address byte |
| req_busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| nce | output | NUM_CS | Chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nwe | output | 1 | Write strobe, active low |
| nre | output | 1 | Read strobe, active low |
| dq_out | output | DW | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | DW | Data bus input |
| rnb | input | 1 | Ready (high) / busy (low) from the flash |

## Verification
The bench measures phase edges cycle by cycle and checks them against the programmed fields. A design that mixed up the timing sets, or was off by one in a counter, would shift the strobe window. Other targets are the turnaround gap after command and after address cycles, and zero-valued fields. A design that ignored the gap, or used the wrong delay field, would start the read early; a zero field could turn into a 256-cycle phase. The bench also checks that the wait phase stretches on a low rnb only when wait enable is set. It checks that a request made during an access, or with the bank disabled, never pulls any chip enable low. Finally it checks the drive-on cycle and that the upper byte is masked on an 8-bit bus.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    localparam int FW = 8;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_ADDR = 2'd2
    } acc_kind_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_WAIT,
        PH_HOLD
    } phase_t;

    // Field order is the register bit order (MSB first).
    typedef struct packed {
        logic [FW-1:0] hiz;
        logic [FW-1:0] hold;
        logic [FW-1:0] wt;
        logic [FW-1:0] setup;
    } tset_t;

    typedef struct packed {
        logic wide;
        logic wait_en;
        logic bank_en;
    } mode_t;

    localparam logic [1:0] CFG_COMMON = 2'd0;
    localparam logic [1:0] CFG_ATTR   = 2'd1;
    localparam logic [1:0] CFG_MODE   = 2'd2;
    localparam logic [1:0] CFG_DELAY  = 2'd3;

    localparam logic [FW-1:0] TSET_RST  = 8'h0A;
    localparam logic [3:0]    DELAY_RST = 4'hF;

    function automatic logic [FW-1:0] at_least_one(input logic [FW-1:0] v);
        return (v == '0) ? FW'(1) : v;
    endfunction

    function automatic tset_t clamp_set(input tset_t t);
        tset_t r;
        r.setup = at_least_one(t.setup);
        r.wt    = at_least_one(t.wt);
        r.hold  = at_least_one(t.hold);
        r.hiz   = t.hiz;
        return r;
    endfunction

endpackage

// File: rtl/nand_timing_regs.sv
module nand_timing_regs
    import nand_cyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output tset_t       common_set,
    output tset_t       attr_set,
    output mode_t       mode,
    output logic [3:0]  cmd_dly,
    output logic [3:0]  addr_dly
);

    always_ff @(posedge clk) begin
        if (rst) begin
            common_set <= '{hiz: TSET_RST, hold: TSET_RST, wt: TSET_RST, setup: TSET_RST};
            attr_set   <= '{hiz: TSET_RST, hold: TSET_RST, wt: TSET_RST, setup: TSET_RST};
            mode       <= '0;
            cmd_dly    <= DELAY_RST;
            addr_dly   <= DELAY_RST;
        end else if (cfg_we) begin
            case (cfg_sel)
                CFG_COMMON: common_set <= tset_t'(cfg_wdata);
                CFG_ATTR:   attr_set   <= tset_t'(cfg_wdata);
                CFG_MODE:   mode       <= mode_t'(cfg_wdata[2:0]);
                default: begin
                    cmd_dly  <= cfg_wdata[3:0];
                    addr_dly <= cfg_wdata[7:4];
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // load_val is a phase length of at least 1; done marks its last cycle.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DW     = 16,
    localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [CSW-1:0]    req_cs,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_busy,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NUM_CS-1:0] nce,
    output logic              cle,
    output logic              ale,
    output logic              nwe,
    output logic              nre,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    input  logic [DW-1:0]     dq_in,
    input  logic              rnb
);

    localparam int HW = DW / 2;
    localparam int EW = FW + 2;
    localparam logic [DW-1:0] LOW_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

    tset_t      common_set, attr_set, ts_q;
    mode_t      mode;
    logic [3:0] cmd_dly, addr_dly;

    nand_timing_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .common_set (common_set),
        .attr_set   (attr_set),
        .mode       (mode),
        .cmd_dly    (cmd_dly),
        .addr_dly   (addr_dly)
    );

    phase_t        state, state_nxt;
    acc_kind_t     kind_q, prev_kind, req_k;
    logic          write_q;
    logic [CSW-1:0] cs_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          rsp_q;
    logic [EW-1:0] elapsed;
    logic          accept, need_gap, t_load, t_done, active, stall;
    logic [FW-1:0] t_val, gap_len;
    tset_t         sel_set;

    nand_phase_timer #(.W(FW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        case (req_kind)
            2'd1:    req_k = KIND_CMD;
            2'd2:    req_k = KIND_ADDR;
            default: req_k = KIND_DATA;
        endcase
    end

    assign accept   = (state == PH_IDLE) && req_valid && mode.bank_en;
    assign sel_set  = clamp_set((req_k == KIND_DATA) ? common_set : attr_set);
    assign need_gap = (req_k == KIND_DATA) && !req_write && (prev_kind != KIND_DATA);
    assign gap_len  = FW'((prev_kind == KIND_CMD) ? cmd_dly : addr_dly) + FW'(1);
    assign stall    = mode.wait_en && !rnb;

    always_comb begin
        state_nxt = state;
        t_load    = 1'b0;
        t_val     = FW'(1);
        case (state)
            PH_IDLE: if (accept) begin
                t_load = 1'b1;
                if (need_gap) begin
                    state_nxt = PH_GAP;
                    t_val     = gap_len;
                end else begin
                    state_nxt = PH_SETUP;
                    t_val     = sel_set.setup;
                end
            end
            PH_GAP: if (t_done) begin
                state_nxt = PH_SETUP;
                t_load    = 1'b1;
                t_val     = ts_q.setup;
            end
            PH_SETUP: if (t_done) begin
                state_nxt = PH_WAIT;
                t_load    = 1'b1;
                t_val     = ts_q.wt;
            end
            PH_WAIT: if (t_done && !stall) begin
                state_nxt = PH_HOLD;
                t_load    = 1'b1;
                t_val     = ts_q.hold;
            end
            PH_HOLD: if (t_done) state_nxt = PH_IDLE;
            default: state_nxt = PH_IDLE;
        endcase
    end

    assign active = (state == PH_SETUP) || (state == PH_WAIT) || (state == PH_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            kind_q    <= KIND_DATA;
            prev_kind <= KIND_DATA;
            write_q   <= 1'b0;
            cs_q      <= '0;
            wdata_q   <= '0;
            ts_q      <= '0;
            rdata_q   <= '0;
            rsp_q     <= 1'b0;
            elapsed   <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                kind_q    <= req_k;
                prev_kind <= req_k;
                write_q   <= req_write || (req_k != KIND_DATA);
                cs_q      <= req_cs;
                wdata_q   <= mode.wide ? req_wdata : (req_wdata & LOW_MASK);
                ts_q      <= sel_set;
            end
            if (active)
                elapsed <= (elapsed == {EW{1'b1}}) ? elapsed : elapsed + EW'(1);
            else
                elapsed <= '0;
            rsp_q <= 1'b0;
            if (state == PH_WAIT && state_nxt == PH_HOLD && !write_q) begin
                rdata_q <= mode.wide ? dq_in : (dq_in & LOW_MASK);
                rsp_q   <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
        assign nce[i] = !(active && (cs_q == CSW'(i)));
    end

    assign cle       = active && (kind_q == KIND_CMD);
    assign ale       = active && (kind_q == KIND_ADDR);
    assign nwe       = !((state == PH_WAIT) && write_q);
    assign nre       = !((state == PH_WAIT) && !write_q);
    assign dq_oe     = active && write_q && (elapsed >= EW'(ts_q.hiz) + EW'(1));
    assign dq_out    = wdata_q;
    assign req_busy  = (state != PH_IDLE);
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] nce,
    input logic              cle,
    input logic              ale,
    input logic              nwe,
    input logic              nre,
    input logic              dq_oe,
    input logic              req_busy,
    input logic              rsp_valid
);

    p_strobe_under_ce_r2: assert property (@(posedge clk) disable iff (rst)
        (!nwe || !nre) |-> (nce != {NUM_CS{1'b1}}));

    p_latch_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    p_latch_under_ce_r3: assert property (@(posedge clk) disable iff (rst)
        (cle || ale) |-> (nce != {NUM_CS{1'b1}}));

    p_single_ce_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nce));

    p_drive_re_high_r5: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> nre);

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !(!nwe && !nre));

    p_rsp_after_re_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!nre));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_busy |-> ((&nce) && nwe && nre && !dq_oe && !cle && !ale));

endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/sim_nand_cycle_gen.sv
module sim_nand_cycle_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic [0:0]  req_cs = '0;
    logic [15:0] req_wdata = '0;
    logic        req_busy, rsp_valid;
    logic [15:0] rsp_rdata, dq_out;
    logic [1:0]  nce;
    logic        cle, ale, nwe, nre, dq_oe;
    logic [15:0] dq_in = 16'hBEEF;
    logic        rnb = 1'b1;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nand_cycle_gen u0 (.*);

    // per-access measurements
    int m_busy, m_ce_first, m_ce_last, m_we_first, m_we_n, m_re_first, m_re_n;
    int m_oe_first, m_oe_last, m_cle_n, m_ale_n, m_other_ce, m_rsp_idx;
    logic [15:0] m_rsp_data, m_dq;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // rel: -2 keep rnb high, -1 hold rnb low throughout, >=0 release at that index
    task automatic access(input logic [1:0] kind, input logic wr, input logic cs,
                          input logic [15:0] d, input int rel, input bit inject);
        m_ce_first = -1; m_ce_last = -1; m_we_first = -1; m_we_n = 0;
        m_re_first = -1; m_re_n = 0; m_oe_first = -1; m_oe_last = -1;
        m_cle_n = 0; m_ale_n = 0; m_other_ce = 0; m_rsp_idx = -1;
        m_rsp_data = '0; m_dq = '0; m_busy = -1;
        @(negedge clk);
        if (rel != -2) rnb = 1'b0;
        req_valid = 1'b1; req_kind = kind; req_write = wr; req_cs = cs; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (!req_busy) begin
                m_busy = i;
                break;
            end
            if (!nce[cs]) begin
                if (m_ce_first < 0) m_ce_first = i;
                m_ce_last = i;
            end
            if (!nce[~cs]) m_other_ce++;
            if (!nwe) begin if (m_we_first < 0) m_we_first = i; m_we_n++; end
            if (!nre) begin if (m_re_first < 0) m_re_first = i; m_re_n++; end
            if (dq_oe) begin
                if (m_oe_first < 0) m_oe_first = i;
                m_oe_last = i;
                m_dq = dq_out;
            end
            if (cle) m_cle_n++;
            if (ale) m_ale_n++;
            if (rsp_valid) begin m_rsp_idx = i; m_rsp_data = rsp_rdata; end
            if (rel >= 0 && i == rel) rnb = 1'b1;
            if (inject && i == 2) begin req_valid = 1'b1; req_cs = ~cs; end
            if (inject && i == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        rnb = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 nce idle", nce, 3);
        chk("R1 nwe", nwe, 1);
        chk("R1 nre", nre, 1);
        chk("R1 cle/ale", {cle, ale}, 0);
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 busy", req_busy, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_default_write;
        cfg(2'd2, 32'h1);
        access(2'd0, 1'b1, 1'b0, 16'hA55A, -2, 1'b0);
        chk("R1 default ce first", m_ce_first, 0);
        chk("R1 default we first", m_we_first, 10);
        chk("R1 default we len", m_we_n, 10);
        chk("R1 default ce last", m_ce_last, 29);
        chk("R1 default busy", m_busy, 30);
        chk("R5 default oe first", m_oe_first, 11);
        chk("R5 default oe last", m_oe_last, 29);
        chk("R7 narrow dq", m_dq, 16'h005A);
        chk("R2 no re on write", m_re_n, 0);
    endtask

    task automatic t_default_cmd_then_read;
        access(2'd1, 1'b0, 1'b1, 16'h0030, -2, 1'b0);
        chk("R3 cle span", m_cle_n, 30);
        chk("R3 no ale", m_ale_n, 0);
        chk("R3 cmd forced write", m_we_n, 10);
        chk("R4 other ce", m_other_ce, 0);
        chk("R4 ce1 span", m_ce_last - m_ce_first + 1, 30);
        access(2'd0, 1'b0, 1'b1, 16'h0, -2, 1'b0);
        chk("R12 default cmd gap", m_ce_first, 16);
        chk("R6 re first", m_re_first, 26);
        chk("R6 re len", m_re_n, 10);
        chk("R6 rsp idx", m_rsp_idx, 36);
        chk("R7 narrow read", m_rsp_data, 16'h00EF);
        chk("R5 no oe on read", m_oe_first, -1);
    endtask

    task automatic t_program;
        cfg(2'd0, 32'h02030402);
        cfg(2'd1, 32'h01020301);
        cfg(2'd2, 32'h5);
        cfg(2'd3, 32'h42);
    endtask

    task automatic t_wide_write;
        access(2'd0, 1'b1, 1'b1, 16'h1234, -2, 1'b0);
        chk("R2 we first", m_we_first, 2);
        chk("R2 we len", m_we_n, 4);
        chk("R2 ce last", m_ce_last, 8);
        chk("R10 busy len", m_busy, 9);
        chk("R5 oe first", m_oe_first, 3);
        chk("R5 oe last", m_oe_last, 8);
        chk("R7 wide dq", m_dq, 16'h1234);
        chk("R4 other ce", m_other_ce, 0);
    endtask

    task automatic t_addr_then_read;
        access(2'd2, 1'b1, 1'b0, 16'h0077, -2, 1'b0);
        chk("R3 ale span", m_ale_n, 6);
        chk("R3 no cle", m_cle_n, 0);
        chk("R3 attr we first", m_we_first, 1);
        chk("R3 attr we len", m_we_n, 3);
        chk("R5 attr oe first", m_oe_first, 2);
        access(2'd0, 1'b0, 1'b0, 16'h0, -2, 1'b0);
        chk("R12 addr gap", m_ce_first, 5);
        chk("R6 re first", m_re_first, 7);
        chk("R6 re len", m_re_n, 4);
        chk("R6 rsp idx", m_rsp_idx, 11);
        chk("R7 wide read", m_rsp_data, 16'hBEEF);
    endtask

    task automatic t_cmd_gap_and_none;
        access(2'd1, 1'b1, 1'b0, 16'h0070, -2, 1'b0);
        chk("R3 cle span", m_cle_n, 6);
        access(2'd0, 1'b0, 1'b0, 16'h0, -2, 1'b0);
        chk("R12 cmd gap", m_ce_first, 3);
        access(2'd0, 1'b0, 1'b0, 16'h0, -2, 1'b0);
        chk("R12 no gap after data", m_ce_first, 0);
    endtask

    task automatic t_wait_stretch;
        cfg(2'd2, 32'h7);
        access(2'd0, 1'b1, 1'b0, 16'h0001, 12, 1'b0);
        chk("R8 stretched we", m_we_n, 11);
        chk("R8 stretched busy", m_busy, 16);
        cfg(2'd2, 32'h5);
        access(2'd0, 1'b1, 1'b0, 16'h0001, -1, 1'b0);
        chk("R8 wait disabled we", m_we_n, 4);
    endtask

    task automatic t_zero_fields;
        cfg(2'd0, 32'h00000000);
        access(2'd0, 1'b1, 1'b0, 16'h0002, -2, 1'b0);
        chk("R11 we first", m_we_first, 1);
        chk("R11 we len", m_we_n, 1);
        chk("R11 busy", m_busy, 3);
        chk("R11 oe first", m_oe_first, 1);
        cfg(2'd0, 32'h02030402);
    endtask

    task automatic t_bank_off;
        int seen;
        seen = 0;
        cfg(2'd2, 32'h4);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1; req_cs = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_busy || nce != 2'b11) seen++;
        end
        req_valid = 1'b0;
        chk("R9 bank off ignored", seen, 0);
        cfg(2'd2, 32'h5);
    endtask

    task automatic t_busy_ignore;
        int seen;
        seen = 0;
        access(2'd0, 1'b1, 1'b0, 16'h00AA, -2, 1'b1);
        chk("R10 injected ce", m_other_ce, 0);
        chk("R10 busy len", m_busy, 9);
        for (int i = 0; i < 4; i++) begin
            if (req_busy || nce != 2'b11) seen++;
            @(negedge clk);
        end
        chk("R10 idle after", seen, 0);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_write();
        t_default_cmd_then_read();
        t_program();
        t_wide_write();
        t_addr_then_read();
        t_cmd_gap_and_none();
        t_wait_stretch();
        t_zero_fields();
        t_bank_off();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule